// File: doc/BRIEF.md
# Texture Bank Overlap Resolver

This block runs once the texture binds for a draw are complete. Each of eight texture units owns two memory regions, an even bank and an odd bank. Each region is given by a base address and a size in bytes. Each unit also carries a residency state: invalid, valid or cached. The block finds regions that collide and asks the residency tracker to drop the units involved from cached to valid.

A `start` pulse latches the in-use mask and begins a scan. The scan takes one cycle per unit and visits units 0 to 7 in order. In a cycle whose unit is in the mask, that unit is tested against its own two banks and against all four bank pairings of each of the other seven units at once. The result leaves as a one-cycle strobe vector with one bit per unit. The tracker applies a strobe only to a unit that is currently cached. `done` pulses together with the strobe of the last step.

Top module: `bank_overlap_resolver`

## Requirements
- R1: Bank A overlaps bank B when A.base <= B.base and A.base + A.size > B.base, or the same holds with A and B swapped. A region that ends exactly where another begins does not overlap it.
- R2: A bank whose size is zero overlaps nothing.
- R3: Unit states are encoded 2'b00 invalid, 2'b01 valid, 2'b10 cached. A pair of different units is tested only when neither unit is invalid.
- R4: Two different units overlap when any of the four pairings even/even, even/odd, odd/even or odd/odd overlaps.
- R5: An active unit whose own even and odd banks overlap gets its strobe bit, whatever its state.
- R6: When active unit i overlaps unit j (j any other unit, in the mask or not), the strobe of that step has both bit i and bit j set.
- R7: Unit k is examined in step k and only if its bit was set in the mask latched at `start`. Its strobe vector appears k+1 cycles after the edge that accepted `start`. A step whose unit is not in the mask shows an all-zero strobe.
- R8: `busy` is high for the eight scan cycles. `done` is high for exactly one cycle, 8 cycles after the accepting edge, and `busy` is low from that cycle on. A `start` while busy is ignored.
- R9: Base plus size is formed one bit wider than the address, so a region that runs past the top of the address space still overlaps correctly.
- R10: After reset `busy`, `done` and `downgrade` are all zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Begin a scan when idle |
| use_mask | input | NU | Units in use, latched at start |
| unit_state | input | 2*NU | Per-unit residency state, 2 bits each |
| even_base | input | NU*AW | Even bank base per unit |
| even_size | input | NU*AW | Even bank size per unit |
| odd_base | input | NU*AW | Odd bank base per unit |
| odd_size | input | NU*AW | Odd bank size per unit |
| downgrade | output | NU | Per-unit downgrade strobe for the current step |
| busy | output | 1 | Scan in progress |
| done | output | 1 | One-cycle pulse at scan end |

## Verification
A self overlap and a pairwise overlap can both be found in the same step. The two findings then share one strobe vector, and the bit of the outer unit has to be set without other bits being lost. The random scenes pack many short regions into a small address window so that both cases occur often, and a directed scene forces them together. Each step's vector is compared in full against a bench model. The bench also checks that `done` coincides with the last step's strobe, and that a `start` raised during the scan neither shifts that strobe nor starts a second scan.

// File: rtl/bank_overlap_resolver.sv
module bank_overlap_resolver #(
  parameter int NU = 8,
  parameter int AW = 20
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic [NU-1:0]    use_mask,
  input  logic [2*NU-1:0]  unit_state,
  input  logic [NU*AW-1:0] even_base,
  input  logic [NU*AW-1:0] even_size,
  input  logic [NU*AW-1:0] odd_base,
  input  logic [NU*AW-1:0] odd_size,
  output logic [NU-1:0]    downgrade,
  output logic             busy,
  output logic             done
);
  localparam int IW = (NU > 1) ? $clog2(NU) : 1;
  localparam logic [IW-1:0] LAST = IW'(NU - 1);

  logic [IW-1:0] idx;
  logic [NU-1:0] mask_q;
  logic [NU-1:0] pair_hit;
  logic          self_hit;
  logic [NU-1:0] step_vec;

  function automatic logic ov(input logic [AW-1:0] ab, input logic [AW-1:0] as,
                              input logic [AW-1:0] bb, input logic [AW-1:0] bs);
    logic [AW:0] ae, be;
    ae = {1'b0, ab} + {1'b0, as};
    be = {1'b0, bb} + {1'b0, bs};
    return (as != '0) && (bs != '0) &&
           (((ab <= bb) && (ae > {1'b0, bb})) || ((bb <= ab) && (be > {1'b0, ab})));
  endfunction

  wire [AW-1:0] ieb = even_base[idx*AW +: AW];
  wire [AW-1:0] ies = even_size[idx*AW +: AW];
  wire [AW-1:0] iob = odd_base[idx*AW +: AW];
  wire [AW-1:0] ios = odd_size[idx*AW +: AW];
  wire          ilive = unit_state[idx*2 +: 2] != 2'b00;

  assign self_hit = ov(ieb, ies, iob, ios);

  for (genvar j = 0; j < NU; j++) begin : g_pair
    wire [AW-1:0] jeb = even_base[j*AW +: AW];
    wire [AW-1:0] jes = even_size[j*AW +: AW];
    wire [AW-1:0] job = odd_base[j*AW +: AW];
    wire [AW-1:0] jos = odd_size[j*AW +: AW];
    assign pair_hit[j] = (idx != IW'(j)) && ilive && (unit_state[j*2 +: 2] != 2'b00) &&
                         (ov(ieb, ies, jeb, jes) || ov(ieb, ies, job, jos) ||
                          ov(iob, ios, jeb, jes) || ov(iob, ios, job, jos));
  end

  always_comb begin
    step_vec = '0;
    if (mask_q[idx]) begin
      step_vec = pair_hit;
      if (self_hit || (|pair_hit)) step_vec[idx] = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      idx       <= '0;
      mask_q    <= '0;
      busy      <= 1'b0;
      done      <= 1'b0;
      downgrade <= '0;
    end else begin
      done      <= 1'b0;
      downgrade <= '0;
      if (!busy) begin
        if (start) begin
          busy   <= 1'b1;
          idx    <= '0;
          mask_q <= use_mask;
        end
      end else begin
        downgrade <= step_vec;
        if (idx == LAST) begin
          busy <= 1'b0;
          done <= 1'b1;
        end else begin
          idx <= idx + 1'b1;
        end
      end
    end
  end
endmodule

module bank_overlap_resolver_chk #(
  parameter int NU = 8
) (
  input logic          clk,
  input logic          rst_n,
  input logic          start,
  input logic          busy,
  input logic          done,
  input logic [NU-1:0] downgrade
);
  a_r8_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);
  a_r8_done_ends_busy: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (!busy && $past(busy)));
  a_r8_start_accepted: assert property (@(posedge clk) disable iff (!rst_n)
    (start && !busy && !done) |=> busy);
  a_r7_strobe_in_scan: assert property (@(posedge clk) disable iff (!rst_n)
    (downgrade != '0) |-> $past(busy));
  a_r8_busy_holds: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !$past(busy)) |=> busy);
endmodule

bind bank_overlap_resolver bank_overlap_resolver_chk #(.NU(NU)) u_chk (
  .clk(clk), .rst_n(rst_n), .start(start), .busy(busy), .done(done), .downgrade(downgrade));

// File: tb/sim_bank_overlap_resolver.sv
module sim_bank_overlap_resolver;
  localparam int NU = 8;
  localparam int AW = 20;

  logic clk = 0, rst_n = 0, start = 0;
  logic [NU-1:0] use_mask = '0;
  logic [1:0]    st [NU];
  logic [AW-1:0] eb [NU], es [NU], ob [NU], os [NU];
  logic [2*NU-1:0]  unit_state;
  logic [NU*AW-1:0] even_base, even_size, odd_base, odd_size;
  logic [NU-1:0] downgrade;
  logic busy, done;
  int checks = 0, errors = 0;

  always #5 clk = ~clk;

  always_comb begin
    for (int k = 0; k < NU; k++) begin
      unit_state[k*2 +: 2]  = st[k];
      even_base[k*AW +: AW] = eb[k];
      even_size[k*AW +: AW] = es[k];
      odd_base[k*AW +: AW]  = ob[k];
      odd_size[k*AW +: AW]  = os[k];
    end
  end

  bank_overlap_resolver #(.NU(NU), .AW(AW)) u0 (
    .clk(clk), .rst_n(rst_n), .start(start), .use_mask(use_mask), .unit_state(unit_state),
    .even_base(even_base), .even_size(even_size), .odd_base(odd_base), .odd_size(odd_size),
    .downgrade(downgrade), .busy(busy), .done(done));

  function automatic bit m_ov(longint ab, longint as, longint bb, longint bs);
    if (as == 0 || bs == 0) return 0;
    return (ab <= bb && ab + as > bb) || (bb <= ab && bb + bs > ab);
  endfunction

  function automatic logic [NU-1:0] m_step(int i, logic [NU-1:0] m);
    logic [NU-1:0] v = '0;
    if (!m[i]) return v;
    if (m_ov(eb[i], es[i], ob[i], os[i])) v[i] = 1;
    for (int j = 0; j < NU; j++)
      if (j != i && st[i] != 2'b00 && st[j] != 2'b00 &&
          (m_ov(eb[i], es[i], eb[j], es[j]) || m_ov(eb[i], es[i], ob[j], os[j]) ||
           m_ov(ob[i], os[i], eb[j], es[j]) || m_ov(ob[i], os[i], ob[j], os[j]))) begin
        v[i] = 1; v[j] = 1;
      end
    return v;
  endfunction

  task automatic chk(string req, longint act, longint exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic scan(string tag, bit poke);
    logic [NU-1:0] m = use_mask;
    @(posedge clk); #1 start = 1;
    @(posedge clk); #1 start = 0;
    chk("R8 busy at start", busy, 1);
    for (int k = 0; k < NU; k++) begin
      @(posedge clk); #1;
      chk({"R4 R5 R6 R7 step ", tag}, downgrade, m_step(k, m));
      chk("R8 done timing", done, k == NU - 1);
      if (poke && k == 3) start = 1;
      if (poke && k == 4) start = 0;
    end
    chk("R8 busy ends", busy, 0);
    @(posedge clk); #1;
    chk("R8 no restart", {busy, done, downgrade}, 0);
  endtask

  task automatic clear_all();
    for (int k = 0; k < NU; k++) begin
      st[k] = 2'b10; eb[k] = AW'(k * 4096); es[k] = 0; ob[k] = AW'(k * 4096 + 2048); os[k] = 0;
    end
  endtask

  initial begin
    void'($urandom(32'd20241));
    clear_all();
    #1;
    chk("R10 reset", {busy, done, downgrade}, 0);
    #22 rst_n = 1;

    clear_all();
    for (int k = 0; k < NU; k++) begin es[k] = 16; os[k] = 16; end
    use_mask = '1;
    scan("disjoint R7", 0);

    clear_all();
    eb[0] = 100; es[0] = 50; eb[1] = 150; es[1] = 10;
    eb[2] = 300; es[2] = 20; ob[2] = 319; os[2] = 5;
    use_mask = 8'h07;
    scan("touch R1 self", 0);

    clear_all();
    eb[3] = 500; es[3] = 0; eb[4] = 500; es[4] = 64;
    ob[5] = 510; os[5] = 8; st[5] = 2'b00;
    eb[6] = 505; es[6] = 4; st[6] = 2'b01;
    use_mask = 8'h78;
    scan("zero R2 invalid R3", 0);

    clear_all();
    eb[7] = 20'hFF000; es[7] = 20'h02000; ob[1] = 20'hFF800; os[1] = 16;
    ob[2] = 20'h00800; os[2] = 16;
    use_mask = 8'h80;
    scan("wrap R9", 0);

    clear_all();
    eb[2] = 1000; es[2] = 40; ob[2] = 1020; os[2] = 40; eb[5] = 1030; es[5] = 5;
    use_mask = 8'h24;
    scan("self and pair R5 R6", 1);

    for (int n = 0; n < 30; n++) begin
      for (int k = 0; k < NU; k++) begin
        st[k] = 2'($urandom % 3);
        eb[k] = AW'($urandom % 512); es[k] = ($urandom % 4 == 0) ? '0 : AW'($urandom % 48);
        ob[k] = AW'($urandom % 512); os[k] = ($urandom % 4 == 0) ? '0 : AW'($urandom % 48);
      end
      use_mask = NU'($urandom);
      scan("random", n == 5);
    end

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    #1000000;
    errors++;
    checks++;
    $display("FAIL watchdog actual=hung expected=finished");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule